// File: doc/BRIEF.md
# Masked Register Move Engine

This block moves 64-bit words among four storage locations: a comparand register, two mask registers and a small word-addressed memory in which every word has its own valid flag. It carries out two kinds of command. A move copies a whole word from one location to another in a single cycle. A segment write places a 16-bit slice into a destination chosen earlier by a select command. Writes into the comparand or into memory can be restricted bit by bit by either mask register: a mask bit of 0 lets the destination bit change, and a mask bit of 1 protects it.

Commands arrive already decoded. Each command has an operation code, a source and destination location code, a mask select, a validity control, and an addressing flag with an absolute address. An address register supplies the memory address when the absolute flag is clear. It steps by one after every memory access that completes. The block shows the write enables and the merged word of the current command as combinational outputs. It raises a one-cycle compare request whenever the comparand or a mask register has just received a complete 64-bit value. The compare itself is done outside the block. The three registers, the address register and a read port into the memory are brought out so that their contents can be observed.

Top module: `mask_move_unit`

## Requirements
- R1: After synchronous reset, the following all hold: the comparand and both mask registers are zero, every memory word reads as zero and invalid, the address register is zero, and the compare request is low. The persistent destination is the comparand with no mask, and the segment counter is at segment 0.
- R2: A move (`cmd_op` = 01) copies the whole source word into the destination at the next clock edge. Location codes are 000 comparand, 001 mask 1, 010 mask 2 and 011 memory.
- R3: The mask select works as follows: 00 means no mask, 01 means mask 1, 10 means mask 2, and 11 is treated as no mask. Only destination bits whose selected mask bit is 0 change. Masking applies only when the destination is the comparand or memory, so a mask register destination is always written whole.
- R4: A move into memory with `cmd_setv` = 1 marks the word valid. With `cmd_setv` = 0 the word's validity is left unchanged.
- R5: A move whose source and destination codes are equal changes nothing: no register, no memory word and no address register change, no write enable is raised and no compare request follows.
- R6: Memory is addressed by `cmd_addr` when `cmd_abs` = 1, and by the address register otherwise. After a move that reads or writes memory, the address register holds that address plus one, or minus one when `ar_down` = 1, wrapping modulo the depth.
- R7: A select command (`cmd_op` = 10) records destination, mask select and validity control as the persistent destination, and returns the segment counter to 0. With `cmd_abs` = 1 it also loads the address register with `cmd_addr`.
- R8: A segment write (`cmd_op` = 11) places `seg_data` in bits 16k+15..16k of the persistent destination, where k is the segment counter. The write is masked as in R3 and then k advances, wrapping after 3.
- R9: `cmp_req` is high for exactly the cycle after a write completes a 64-bit value in the comparand or a mask register. Such a write is either a move or the segment write with k = 3. `cmp_req` never follows a write to memory.
- R10: For a memory destination, only the segment write with k = 3 steps the address register and, when the recorded validity control is 1, marks the word valid. Earlier segments change only data bits.
- R11: `wr_en` bit 0 is the comparand, bit 1 mask 1, bit 2 mask 2 and bit 3 memory. At most one bit is high. `wr_data` shows the merged word that the command writes.
- R12: Location codes 100 to 111 name nothing. A move that uses such a code, and segment writes while such a code is the persistent destination, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | 00 idle, 01 move, 10 select destination, 11 segment write |
| cmd_src | input | 3 | Source location code for a move |
| cmd_dst | input | 3 | Destination location code for a move or select |
| cmd_msel | input | 2 | Mask select |
| cmd_setv | input | 1 | Validity control for memory destinations |
| cmd_abs | input | 1 | Use `cmd_addr` instead of the address register |
| cmd_addr | input | AW | Absolute memory address |
| seg_data | input | SEG_W | Segment payload |
| ar_down | input | 1 | Step the address register downward |
| rd_addr | input | AW | Observation read address |
| rd_data | output | WORD_W | Memory word at `rd_addr` |
| rd_vld | output | 1 | Valid flag at `rd_addr` |
| cmp_q | output | WORD_W | Comparand register |
| msk1_q | output | WORD_W | Mask register 1 |
| msk2_q | output | WORD_W | Mask register 2 |
| ar_q | output | AW | Address register |
| wr_en | output | 4 | Write enables of the current command |
| wr_data | output | WORD_W | Merged word of the current command |
| cmp_req | output | 1 | Compare request pulse |

## Verification
The bench uses the default parameters: 64-bit words, 16-bit segments (so four segments complete a word) and sixteen memory words. With only sixteen words, a downward step from address 0 wraps to 15 within a single move, and the wrap is checked. With four segments, a write sequence can be interrupted after two segments, the destination reselected, and the restart from segment 0 observed. A memory destination is also inspected after three segments, which shows that validity and the address step wait for the fourth.

// File: rtl/mmv_pkg.sv
package mmv_pkg;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_MOVE   = 2'd1,
        OP_SELDST = 2'd2,
        OP_SEGWR  = 2'd3
    } mmv_op_e;

    typedef enum logic [1:0] {
        MS_NONE  = 2'd0,
        MS_ONE   = 2'd1,
        MS_TWO   = 2'd2,
        MS_SPARE = 2'd3
    } msel_e;

    localparam int unsigned N_LOC  = 4;
    localparam logic [2:0] LOC_CMP  = 3'd0;
    localparam logic [2:0] LOC_MSK1 = 3'd1;
    localparam logic [2:0] LOC_MSK2 = 3'd2;
    localparam logic [2:0] LOC_MEM  = 3'd3;

    typedef struct packed {
        logic [2:0] dst;
        logic [1:0] msel;
        logic       setv;
    } pdst_t;

    function automatic logic loc_ok(input logic [2:0] c);
        return c < 3'(N_LOC);
    endfunction

    function automatic logic loc_maskable(input logic [2:0] c);
        return (c == LOC_CMP) || (c == LOC_MEM);
    endfunction

    function automatic logic loc_is_reg(input logic [2:0] c);
        return (c == LOC_CMP) || (c == LOC_MSK1) || (c == LOC_MSK2);
    endfunction

    function automatic logic [N_LOC-1:0] loc_onehot(input logic [2:0] c);
        return N_LOC'(1) << c;
    endfunction

    function automatic logic msel_active(input logic [1:0] m);
        return (m == MS_ONE) || (m == MS_TWO);
    endfunction

endpackage

// File: rtl/mmv_seg_ctrl.sv
module mmv_seg_ctrl
    import mmv_pkg::*;
#(
    parameter  int unsigned NSEG = 4,
    localparam int unsigned IW   = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_en,
    input  pdst_t         sel_val,
    input  logic          seg_en,
    output pdst_t         cur,
    output logic [IW-1:0] seg_idx,
    output logic          seg_last
);

    assign seg_last = (seg_idx == IW'(NSEG - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '{dst: LOC_CMP, msel: MS_NONE, setv: 1'b0};
            seg_idx <= '0;
        end else if (sel_en) begin
            cur     <= sel_val;
            seg_idx <= '0;
        end else if (seg_en) begin
            seg_idx <= seg_last ? '0 : seg_idx + IW'(1);
        end
    end

endmodule

// File: rtl/mmv_seg_insert.sv
module mmv_seg_insert #(
    parameter  int unsigned WORD_W = 64,
    parameter  int unsigned SEG_W  = 16,
    localparam int unsigned NSEG   = WORD_W / SEG_W,
    localparam int unsigned IW     = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic [WORD_W-1:0] base,
    input  logic [SEG_W-1:0]  seg,
    input  logic [IW-1:0]     idx,
    output logic [WORD_W-1:0] word
);

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign word[s*SEG_W +: SEG_W] = (idx == IW'(s)) ? seg : base[s*SEG_W +: SEG_W];
    end

endmodule

// File: rtl/mmv_merge.sv
module mmv_merge #(
    parameter int unsigned WORD_W = 64
) (
    input  logic [WORD_W-1:0] old_w,
    input  logic [WORD_W-1:0] new_w,
    input  logic [WORD_W-1:0] keep_w,
    output logic [WORD_W-1:0] res_w
);

    // a set bit in keep_w protects the old destination bit
    assign res_w = (old_w & keep_w) | (new_w & ~keep_w);

endmodule

// File: rtl/mmv_store.sv
module mmv_store #(
    parameter  int unsigned WORD_W = 64,
    parameter  int unsigned DEPTH  = 16,
    localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              mark_valid,
    input  logic [AW-1:0]     a_addr,
    output logic [WORD_W-1:0] a_data,
    input  logic [AW-1:0]     b_addr,
    output logic [WORD_W-1:0] b_data,
    output logic              b_vld
);

    logic [WORD_W-1:0] words [DEPTH];
    logic [DEPTH-1:0]  vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
            vld <= '0;
        end else if (we) begin
            words[waddr] <= wdata;
            if (mark_valid) begin
                vld[waddr] <= 1'b1;
            end
        end
    end

    assign a_data = words[a_addr];
    assign b_data = words[b_addr];
    assign b_vld  = vld[b_addr];

endmodule

// File: rtl/mask_move_unit.sv
module mask_move_unit
    import mmv_pkg::*;
#(
    parameter  int unsigned WORD_W = 64,
    parameter  int unsigned SEG_W  = 16,
    parameter  int unsigned DEPTH  = 16,
    localparam int unsigned NSEG   = WORD_W / SEG_W,
    localparam int unsigned SIW    = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_op,
    input  logic [2:0]        cmd_src,
    input  logic [2:0]        cmd_dst,
    input  logic [1:0]        cmd_msel,
    input  logic              cmd_setv,
    input  logic              cmd_abs,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [SEG_W-1:0]  seg_data,
    input  logic              ar_down,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_vld,
    output logic [WORD_W-1:0] cmp_q,
    output logic [WORD_W-1:0] msk1_q,
    output logic [WORD_W-1:0] msk2_q,
    output logic [AW-1:0]     ar_q,
    output logic [3:0]        wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              cmp_req
);

    mmv_op_e           op;
    pdst_t             pcur;
    pdst_t             sel_val;
    logic [SIW-1:0]    seg_idx;
    logic              seg_last;
    logic              sel_en;
    logic              seg_go;
    logic              mv_go;
    logic              do_write;
    logic              word_done;
    logic [AW-1:0]     mv_addr;
    logic [AW-1:0]     acc_addr;
    logic [AW-1:0]     step_base;
    logic [2:0]        tgt;
    logic [1:0]        msel_now;
    logic [WORD_W-1:0] mem_word;
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] old_word;
    logic [WORD_W-1:0] ins_word;
    logic [WORD_W-1:0] new_word;
    logic [WORD_W-1:0] mask_word;
    logic [WORD_W-1:0] eff_mask;
    logic [WORD_W-1:0] merged;
    logic              mem_mark;
    logic              mem_touch;

    assign op       = mmv_op_e'(cmd_op);
    assign sel_en   = (op == OP_SELDST);
    assign sel_val  = '{dst: cmd_dst, msel: cmd_msel, setv: cmd_setv};
    assign mv_go    = (op == OP_MOVE) && loc_ok(cmd_src) && loc_ok(cmd_dst)
                      && (cmd_src != cmd_dst);
    assign seg_go   = (op == OP_SEGWR) && loc_ok(pcur.dst);
    assign do_write = mv_go || seg_go;
    assign word_done = mv_go || (seg_go && seg_last);

    assign mv_addr   = cmd_abs ? cmd_addr : ar_q;
    assign acc_addr  = mv_go ? mv_addr : ar_q;
    assign step_base = acc_addr;
    assign tgt       = mv_go ? cmd_dst : pcur.dst;
    assign msel_now  = mv_go ? cmd_msel : pcur.msel;

    mmv_seg_ctrl #(.NSEG(NSEG)) u_seg (
        .clk      (clk),
        .rst      (rst),
        .sel_en   (sel_en),
        .sel_val  (sel_val),
        .seg_en   (seg_go),
        .cur      (pcur),
        .seg_idx  (seg_idx),
        .seg_last (seg_last)
    );

    mmv_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .clk        (clk),
        .rst        (rst),
        .we         (wr_en[LOC_MEM]),
        .waddr      (acc_addr),
        .wdata      (merged),
        .mark_valid (mem_mark),
        .a_addr     (acc_addr),
        .a_data     (mem_word),
        .b_addr     (rd_addr),
        .b_data     (rd_data),
        .b_vld      (rd_vld)
    );

    always_comb begin
        unique case (cmd_src)
            LOC_CMP:  src_word = cmp_q;
            LOC_MSK1: src_word = msk1_q;
            LOC_MSK2: src_word = msk2_q;
            default:  src_word = mem_word;
        endcase
    end

    always_comb begin
        unique case (tgt)
            LOC_CMP:  old_word = cmp_q;
            LOC_MSK1: old_word = msk1_q;
            LOC_MSK2: old_word = msk2_q;
            default:  old_word = mem_word;
        endcase
    end

    always_comb begin
        unique case (msel_e'(msel_now))
            MS_ONE:  mask_word = msk1_q;
            MS_TWO:  mask_word = msk2_q;
            default: mask_word = '0;
        endcase
    end

    mmv_seg_insert #(.WORD_W(WORD_W), .SEG_W(SEG_W)) u_ins (
        .base (old_word),
        .seg  (seg_data),
        .idx  (seg_idx),
        .word (ins_word)
    );

    assign new_word = mv_go ? src_word : ins_word;
    assign eff_mask = (loc_maskable(tgt) && msel_active(msel_now)) ? mask_word : '0;

    mmv_merge #(.WORD_W(WORD_W)) u_merge (
        .old_w  (old_word),
        .new_w  (new_word),
        .keep_w (eff_mask),
        .res_w  (merged)
    );

    assign wr_en   = do_write ? loc_onehot(tgt) : '0;
    assign wr_data = merged;

    assign mem_mark  = mv_go ? cmd_setv : (pcur.setv && seg_last);
    assign mem_touch = mv_go ? ((cmd_src == LOC_MEM) || (cmd_dst == LOC_MEM))
                             : (seg_go && seg_last && (tgt == LOC_MEM));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q   <= '0;
            msk1_q  <= '0;
            msk2_q  <= '0;
            ar_q    <= '0;
            cmp_req <= 1'b0;
        end else begin
            if (wr_en[LOC_CMP])  cmp_q  <= merged;
            if (wr_en[LOC_MSK1]) msk1_q <= merged;
            if (wr_en[LOC_MSK2]) msk2_q <= merged;
            if (mem_touch) begin
                ar_q <= ar_down ? step_base - AW'(1) : step_base + AW'(1);
            end else if (sel_en && cmd_abs) begin
                ar_q <= cmd_addr;
            end
            cmp_req <= word_done && loc_is_reg(tgt);
        end
    end

endmodule

// File: rtl/mmv_checker.sv
module mmv_checker #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned AW     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cmd_op,
    input logic [2:0]        cmd_src,
    input logic [2:0]        cmd_dst,
    input logic              cmd_abs,
    input logic [AW-1:0]     cmd_addr,
    input logic              ar_down,
    input logic [AW-1:0]     ar_q,
    input logic [3:0]        wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic              cmp_req,
    input logic [WORD_W-1:0] cmp_q,
    input logic [WORD_W-1:0] msk1_q,
    input logic [WORD_W-1:0] msk2_q,
    input logic [WORD_W-1:0] eff_mask
);

    a_r11_wr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

    a_r9_req_after_reg: assert property (@(posedge clk) disable iff (rst)
        cmp_req |-> $past(|wr_en[2:0]));

    a_r9_no_req_mem: assert property (@(posedge clk) disable iff (rst)
        wr_en[3] |=> !cmp_req);

    a_r3_cmp_protected: assert property (@(posedge clk) disable iff (rst)
        wr_en[0] |=> (((cmp_q ^ $past(cmp_q)) & $past(eff_mask)) == '0));

    a_r3_mask_whole: assert property (@(posedge clk) disable iff (rst)
        wr_en[1] |=> (msk1_q == $past(wr_data)));

    a_r5_self_move: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd1 && cmd_src == cmd_dst) |=>
            ($stable(cmp_q) && $stable(msk1_q) && $stable(msk2_q) && $stable(ar_q)));

    a_r6_step_up: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd1 && cmd_src != cmd_dst && cmd_src < 3'd4
         && cmd_dst == 3'd3 && !ar_down) |=>
            (ar_q == $past(cmd_abs ? cmd_addr : ar_q) + AW'(1)));

endmodule

bind mask_move_unit mmv_checker #(.WORD_W(WORD_W), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_op   (cmd_op),
    .cmd_src  (cmd_src),
    .cmd_dst  (cmd_dst),
    .cmd_abs  (cmd_abs),
    .cmd_addr (cmd_addr),
    .ar_down  (ar_down),
    .ar_q     (ar_q),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cmp_req  (cmp_req),
    .cmp_q    (cmp_q),
    .msk1_q   (msk1_q),
    .msk2_q   (msk2_q),
    .eff_mask (eff_mask)
);

// File: tb/tb_mask_move_unit.sv
module tb_mask_move_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_src, cmd_dst;
    logic [1:0]  cmd_msel;
    logic        cmd_setv, cmd_abs, ar_down;
    logic [3:0]  cmd_addr, rd_addr, ar_q;
    logic [15:0] seg_data;
    logic [63:0] rd_data, cmp_q, msk1_q, msk2_q, wr_data;
    logic        rd_vld, cmp_req;
    logic [3:0]  wr_en;

    always #4 clk = ~clk;

    mask_move_unit dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
        .cmd_msel(cmd_msel), .cmd_setv(cmd_setv), .cmd_abs(cmd_abs), .cmd_addr(cmd_addr),
        .seg_data(seg_data), .ar_down(ar_down), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_vld(rd_vld), .cmp_q(cmp_q), .msk1_q(msk1_q), .msk2_q(msk2_q), .ar_q(ar_q),
        .wr_en(wr_en), .wr_data(wr_data), .cmp_req(cmp_req)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [63:0] c, m1, m2;
        logic [3:0]  ar;
        logic        req;
        string       tag;
    } exp_t;
    exp_t q[$];

    // requirement-level model of the visible state
    logic [63:0] e_cmp = '0, e_m1 = '0, e_m2 = '0;
    logic [63:0] e_mem [16];
    logic        e_vld [16];
    logic [3:0]  e_ar = '0;
    logic [2:0]  p_dst = 3'd0;
    logic [1:0]  p_ms = 2'd0;
    logic        p_sv = 1'b0;
    int          p_seg = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_loc(input logic [2:0] c, input logic [3:0] a);
        case (c)
            3'd0:    return e_cmp;
            3'd1:    return e_m1;
            3'd2:    return e_m2;
            default: return e_mem[a];
        endcase
    endfunction

    task automatic drive(input logic [1:0] op, input logic [2:0] src, input logic [2:0] dst,
                         input logic [1:0] ms, input logic sv, input logic ab,
                         input logic [3:0] ad, input logic [15:0] sd, input logic dn,
                         input string tag);
        logic [63:0] oldw, neww, mk, res;
        logic [2:0]  t;
        logic [1:0]  m;
        logic [3:0]  a, en;
        logic        wen, last, mark, touch;
        exp_t        e;
        oldw = '0; neww = '0; mk = '0; res = '0; t = 3'd0; m = 2'd0; a = e_ar;
        en = '0; wen = 1'b0; last = 1'b0; mark = 1'b0; touch = 1'b0;
        @(negedge clk);
        cmd_op = op; cmd_src = src; cmd_dst = dst; cmd_msel = ms; cmd_setv = sv;
        cmd_abs = ab; cmd_addr = ad; seg_data = sd; ar_down = dn;
        if (op == 2'd1) begin
            if (src < 3'd4 && dst < 3'd4 && src != dst) begin
                a = ab ? ad : e_ar; t = dst; m = ms;
                oldw = rd_loc(dst, a); neww = rd_loc(src, a);
                wen = 1'b1; last = 1'b1; mark = sv; touch = (src == 3'd3 || dst == 3'd3);
            end
        end else if (op == 2'd3) begin
            if (p_dst < 3'd4) begin
                t = p_dst; m = p_ms; oldw = rd_loc(t, a); neww = oldw;
                neww[p_seg*16 +: 16] = sd;
                wen = 1'b1; last = (p_seg == 3); mark = p_sv && last;
                touch = last && (t == 3'd3);
                p_seg = (p_seg + 1) % 4;
            end
        end
        if (wen) begin
            if (t == 3'd0 || t == 3'd3)
                mk = (m == 2'd1) ? e_m1 : (m == 2'd2) ? e_m2 : 64'h0;
            res = (oldw & mk) | (neww & ~mk);
            en  = 4'b0001 << t;
        end
        #1;
        check({tag, " R11 wr_en"}, {60'd0, wr_en}, {60'd0, en});
        if (wen) check({tag, " R11 wr_data"}, wr_data, res);
        if (wen) begin
            case (t)
                3'd0:    e_cmp = res;
                3'd1:    e_m1 = res;
                3'd2:    e_m2 = res;
                default: begin e_mem[a] = res; if (mark) e_vld[a] = 1'b1; end
            endcase
        end
        if (op == 2'd2) begin
            p_dst = dst; p_ms = ms; p_sv = sv; p_seg = 0;
        end
        if (touch) e_ar = dn ? a - 4'd1 : a + 4'd1;
        else if (op == 2'd2 && ab) e_ar = ad;
        e.c = e_cmp; e.m1 = e_m1; e.m2 = e_m2; e.ar = e_ar;
        e.req = wen && last && (t != 3'd3); e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #1 cmd_op = 2'd0;
    endtask

    task automatic mem_chk(input logic [3:0] ad, input string tag);
        @(negedge clk);
        rd_addr = ad;
        #1;
        check({tag, " data"}, rd_data, e_mem[ad]);
        check({tag, " valid"}, {63'd0, rd_vld}, {63'd0, e_vld[ad]});
    endtask

    // monitor: compares each queued expectation after the edge it belongs to
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " cmp"}, cmp_q, e.c);
                check({e.tag, " msk1"}, msk1_q, e.m1);
                check({e.tag, " msk2"}, msk2_q, e.m2);
                check({e.tag, " ar"}, {60'd0, ar_q}, {60'd0, e.ar});
                check({e.tag, " R9 cmp_req"}, {63'd0, cmp_req}, {63'd0, e.req});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin e_mem[i] = '0; e_vld[i] = 1'b0; end
        rst = 1'b1; cmd_op = 2'd0; cmd_src = '0; cmd_dst = '0; cmd_msel = '0;
        cmd_setv = 1'b0; cmd_abs = 1'b0; cmd_addr = '0; seg_data = '0; ar_down = 1'b0;
        rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check("R1 cmp", cmp_q, 64'h0);
        check("R1 msk1", msk1_q, 64'h0);
        check("R1 msk2", msk2_q, 64'h0);
        check("R1 ar", {60'd0, ar_q}, 64'h0);
        check("R1 cmp_req", {63'd0, cmp_req}, 64'h0);
        mem_chk(4'd0, "R1 mem0");
        // R1 R8 default persistent destination is the comparand, unmasked
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h1111, 1'b0, "R1 R8 seg0");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h2222, 1'b0, "R8 seg1");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h3333, 1'b0, "R8 seg2");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h4444, 1'b0, "R9 R8 seg3");
        // R7 select mask 1, fill it
        drive(2'd2, 3'd0, 3'd1, 2'd0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0, "R7 sel msk1");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'hFFFF, 1'b0, "R8 m1 s0");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'hFFFF, 1'b0, "R8 m1 s1");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h0000, 1'b0, "R8 m1 s2");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h0000, 1'b0, "R9 m1 s3");
        // R7 absolute select loads AR, reselect restarts counter
        drive(2'd2, 3'd0, 3'd2, 2'd0, 1'b0, 1'b1, 4'd5, 16'h0, 1'b0, "R7 abs loads ar");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'hAAAA, 1'b0, "R8 partial s0");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'hAAAA, 1'b0, "R8 partial s1");
        drive(2'd2, 3'd0, 3'd2, 2'd0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0, "R7 reselect");
        for (int i = 0; i < 4; i++)
            drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'hFF00, 1'b0, "R7 R9 m2 restart");
        // moves
        drive(2'd1, 3'd0, 3'd3, 2'd0, 1'b1, 1'b1, 4'd2, 16'h0, 1'b0, "R2 R4 R6 cmp to mem2");
        mem_chk(4'd2, "R2 R4 mem2");
        drive(2'd1, 3'd2, 3'd3, 2'd1, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0, "R3 R4 masked mem at ar");
        mem_chk(4'd3, "R3 R4 mem3");
        drive(2'd1, 3'd3, 3'd0, 2'd2, 1'b0, 1'b1, 4'd2, 16'h0, 1'b1, "R3 R6 mem to cmp down");
        drive(2'd1, 3'd1, 3'd2, 2'd1, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0, "R3 mask dest whole");
        drive(2'd1, 3'd0, 3'd0, 2'd1, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0, "R5 self cmp");
        drive(2'd1, 3'd3, 3'd3, 2'd0, 1'b1, 1'b1, 4'd7, 16'h0, 1'b0, "R5 self mem");
        mem_chk(4'd7, "R5 mem7");
        drive(2'd1, 3'd0, 3'd3, 2'd3, 1'b1, 1'b1, 4'd0, 16'h0, 1'b1, "R3 R6 msel11 wrap");
        mem_chk(4'd0, "R3 mem0");
        // R12 unknown codes
        drive(2'd1, 3'd5, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0, "R12 bad src");
        drive(2'd1, 3'd0, 3'd6, 2'd0, 1'b1, 1'b0, 4'd0, 16'h0, 1'b0, "R12 bad dst");
        drive(2'd2, 3'd0, 3'd7, 2'd0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0, "R12 bad persistent");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h5A5A, 1'b0, "R12 seg ignored");
        // R10 segments into memory
        drive(2'd2, 3'd0, 3'd3, 2'd1, 1'b1, 1'b1, 4'd9, 16'h0, 1'b0, "R7 sel mem9");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h1234, 1'b0, "R10 mem s0");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h5678, 1'b0, "R10 mem s1");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'h9ABC, 1'b0, "R10 mem s2");
        mem_chk(4'd9, "R10 before last");
        drive(2'd3, 3'd0, 3'd0, 2'd0, 1'b0, 1'b0, 4'd0, 16'hDEF0, 1'b0, "R10 mem s3");
        mem_chk(4'd9, "R10 after last");
        drive(2'd1, 3'd3, 3'd1, 2'd0, 1'b0, 1'b1, 4'd9, 16'h0, 1'b0, "R2 mem to msk1");
        repeat (3) @(posedge clk);
        check("queue drained", 64'(q.size()), 64'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule